// File: doc/BRIEF.md
# PCM Highway Transmit Slot Formatter

This block places one channel's outgoing samples on a serial PCM highway. It runs on the highway bit clock. A rising frame sync restarts a bit-position counter. At the start of each frame the block captures the sample, the mode and the status inputs. Starting at the channel's programmed time slot, it shifts the result out most significant bit first, one bit per clock, and raises a drive enable for exactly the bits it owns.

There are three formats:

- **Companded mode:** one 8-bit G.711 byte. In A-law the byte gets alternate bit inversion.
- **Signaling mode:** the companded byte, followed with no gap by a status byte in the next slot.
- **Linear mode:** a 16-bit two's-complement word spread over two adjacent slots.

If the channel is deactivated, its voice bits are not driven. The status slot is still driven.

Top module: `pcm_tx_formatter`

## Requirements
- R1: After reset, and until the first rising frame sync, `tx_en_o` and `tx_data_o` are both 0.
- R2: A rising `fsync_i` sampled at a clock edge makes the next clock frame bit position 0. Slot `n` then begins at position 8·n. A sync held high for a second clock does not restart the frame.
- R3: When `mode_i` is 2'b00 and `alaw_i` is 0, the byte `sample_i[7:0]` is sent MSB first over 8 clocks. `tx_en_o` is high for exactly those 8 clocks.
- R4: When `alaw_i` is 1 in a companded mode, the byte sent is `sample_i[7:0]` XOR 8'h55.
- R5: When `mode_i[1]` is 1, `sample_i[15:0]` is sent sign bit first over 16 consecutive clocks (two slots), and `alaw_i` has no effect.
- R6: When `mode_i` is 2'b01, the companded byte is followed on the very next clock by the status byte. The status byte has `hook_i` in bit 7, `det2_i` in bit 6, `fail_i` in bit 2, and 0 in bits 5..3 and 1..0. The enable is high for 16 clocks.
- R7: With `chan_en_i` at 0, nothing is driven in companded or linear mode. In signaling mode, only the 8 status bits at slot+1 are driven.
- R8: All inputs other than `fsync_i` are sampled only at the frame sync edge. Changing them mid-frame has no effect on the bits sent in that frame.
- R9: `tx_data_o` is 0 whenever `tx_en_o` is 0.
- R10: Bits that would fall at or beyond position 8·SLOTS are never driven. A two-slot format placed in the last slot therefore loses its second byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Highway bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fsync_i | input | 1 | Frame sync; its rising edge starts a frame |
| slot_i | input | SLOT_W | Channel's starting time slot |
| mode_i | input | 2 | 00 companded, 01 companded plus status, 1x linear |
| alaw_i | input | 1 | 1 selects A-law inversion, 0 mu-law |
| chan_en_i | input | 1 | Channel active |
| sample_i | input | 16 | Linear word, or companded byte in [7:0] |
| hook_i | input | 1 | Debounced hook status |
| det2_i | input | 1 | Second detector status |
| fail_i | input | 1 | Fail flag |
| tx_data_o | output | 1 | Serial highway data |
| tx_en_o | output | 1 | Highway drive enable |

## Verification
Two situations can coincide with another event in the same clock:

- **Held sync during a burst:** a frame sync held high for two clocks overlaps the first bit of a slot-0 burst. The bench checks that the frame does not restart, so slot 0 still sends all of its bits.
- **Mid-frame input changes during a burst:** the bench scrambles every input on the clock after capture, while the burst is in progress. It then judges each bit against the values latched at the sync.

Random frames mix all modes, laws, slots and activation states. A bench function predicts enable and data for every bit position.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;

    localparam int SLOT_BITS = 8;

    typedef struct packed {
        logic [15:0] word;      // bits to send, MSB first
        logic        wide;      // voice part spans two slots
        logic        voice_on;  // voice part is driven
        logic        sig_on;    // status byte follows voice byte
    } tx_cfg_t;

endpackage

// File: rtl/pcm_tx_frame_timer.sv
module pcm_tx_frame_timer #(
    parameter int FRAME_BITS = 256,
    parameter int PW         = $clog2(FRAME_BITS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fsync_i,
    output logic          frame_start_o,
    output logic [PW-1:0] pos_o,
    output logic          in_frame_o
);

    localparam logic [PW-1:0] END_POS = PW'(FRAME_BITS);

    typedef struct packed {
        logic          fs_prev;
        logic          valid;
        logic [PW-1:0] pos;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    assign frame_start_o = fsync_i & ~tmr_q.fs_prev;

    always_comb begin
        tmr_d         = tmr_q;
        tmr_d.fs_prev = fsync_i;
        if (frame_start_o) begin
            tmr_d.valid = 1'b1;
            tmr_d.pos   = '0;
        end else if (tmr_q.valid && (tmr_q.pos != END_POS)) begin
            tmr_d.pos = tmr_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign pos_o      = tmr_q.pos;
    assign in_frame_o = tmr_q.valid && (tmr_q.pos < END_POS);

    // R2: a sync edge lands the frame at position 0
    a_r2_sync_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_o |=> (pos_o == '0) && in_frame_o);

    // R2: without a new edge the position moves on by one
    a_r2_pos_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (in_frame_o && !frame_start_o) |=> (pos_o == $past(pos_o) + 1'b1));

endmodule

// File: rtl/pcm_tx_packer.sv
module pcm_tx_packer
    import pcm_tx_pkg::*;
#(
    parameter logic [7:0] ALAW_MASK = 8'h55,
    parameter int         HOOK_POS  = 7,
    parameter int         DET2_POS  = 6,
    parameter int         FAIL_POS  = 2
) (
    input  logic [1:0]  mode_i,
    input  logic        alaw_i,
    input  logic        chan_en_i,
    input  logic [15:0] sample_i,
    input  logic        hook_i,
    input  logic        det2_i,
    input  logic        fail_i,
    output tx_cfg_t     cfg_o
);

    logic [7:0] sig_byte;
    logic [7:0] comp_byte;

    for (genvar b = 0; b < 8; b++) begin : g_sig
        if (b == HOOK_POS) begin : g_hook
            assign sig_byte[b] = hook_i;
        end else if (b == DET2_POS) begin : g_det2
            assign sig_byte[b] = det2_i;
        end else if (b == FAIL_POS) begin : g_fail
            assign sig_byte[b] = fail_i;
        end else begin : g_rsvd
            assign sig_byte[b] = 1'b0;
        end
    end

    assign comp_byte = sample_i[7:0] ^ (alaw_i ? ALAW_MASK : 8'h00);

    always_comb begin
        cfg_o          = '0;
        cfg_o.voice_on = chan_en_i;
        if (mode_i[1]) begin
            cfg_o.word = sample_i;
            cfg_o.wide = 1'b1;
        end else begin
            cfg_o.wide   = 1'b0;
            cfg_o.sig_on = mode_i[0];
            cfg_o.word   = {comp_byte, (mode_i[0] ? sig_byte : 8'h00)};
        end
    end

endmodule

// File: rtl/pcm_tx_serializer.sv
module pcm_tx_serializer
    import pcm_tx_pkg::*;
#(
    parameter int SLOTS  = 32,
    parameter int SLOT_W = $clog2(SLOTS),
    parameter int PW     = $clog2(SLOTS * SLOT_BITS + 1)
) (
    input  logic [PW-1:0]     pos_i,
    input  logic              in_frame_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  tx_cfg_t           cfg_i,
    output logic              tx_en_o,
    output logic              tx_data_o
);

    logic [PW-1:0] start_pos;
    logic [PW:0]   diff;
    logic          past_start;
    logic [PW-1:0] rel;
    logic          in_voice;
    logic          in_sig;
    logic [3:0]    idx;

    assign start_pos  = PW'(slot_i) * PW'(SLOT_BITS);
    assign diff       = {1'b0, pos_i} - {1'b0, start_pos};
    assign past_start = ~diff[PW];
    assign rel        = diff[PW-1:0];
    assign idx        = rel[3:0];

    always_comb begin
        in_voice = 1'b0;
        in_sig   = 1'b0;
        if (in_frame_i && past_start) begin
            if (cfg_i.voice_on) begin
                in_voice = cfg_i.wide ? (rel < PW'(16)) : (rel < PW'(8));
            end
            if (cfg_i.sig_on) begin
                in_sig = (rel >= PW'(8)) && (rel < PW'(16));
            end
        end
    end

    assign tx_en_o   = in_voice | in_sig;
    assign tx_data_o = tx_en_o & cfg_i.word[4'd15 - idx];

endmodule

// File: rtl/pcm_tx_formatter.sv
module pcm_tx_formatter
    import pcm_tx_pkg::*;
#(
    parameter  int SLOTS      = 32,
    localparam int SLOT_W     = $clog2(SLOTS),
    localparam int FRAME_BITS = SLOTS * SLOT_BITS,
    localparam int PW         = $clog2(FRAME_BITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic [1:0]        mode_i,
    input  logic              alaw_i,
    input  logic              chan_en_i,
    input  logic [15:0]       sample_i,
    input  logic              hook_i,
    input  logic              det2_i,
    input  logic              fail_i,
    output logic              tx_data_o,
    output logic              tx_en_o
);

    typedef struct packed {
        tx_cfg_t           cfg;
        logic [SLOT_W-1:0] slot;
        logic [4:0]        run;   // consecutive driven clocks, for checking
    } top_t;

    top_t st_d, st_q;

    logic          frame_start;
    logic [PW-1:0] pos;
    logic          in_frame;
    tx_cfg_t       cfg_new;

    pcm_tx_frame_timer #(
        .FRAME_BITS (FRAME_BITS),
        .PW         (PW)
    ) u_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .fsync_i       (fsync_i),
        .frame_start_o (frame_start),
        .pos_o         (pos),
        .in_frame_o    (in_frame)
    );

    pcm_tx_packer u_packer (
        .mode_i    (mode_i),
        .alaw_i    (alaw_i),
        .chan_en_i (chan_en_i),
        .sample_i  (sample_i),
        .hook_i    (hook_i),
        .det2_i    (det2_i),
        .fail_i    (fail_i),
        .cfg_o     (cfg_new)
    );

    pcm_tx_serializer #(
        .SLOTS  (SLOTS),
        .SLOT_W (SLOT_W),
        .PW     (PW)
    ) u_ser (
        .pos_i      (pos),
        .in_frame_i (in_frame),
        .slot_i     (st_q.slot),
        .cfg_i      (st_q.cfg),
        .tx_en_o    (tx_en_o),
        .tx_data_o  (tx_data_o)
    );

    always_comb begin
        st_d = st_q;
        if (frame_start) begin
            st_d.cfg  = cfg_new;
            st_d.slot = slot_i;
        end
        if (!tx_en_o) begin
            st_d.run = '0;
        end else if (st_q.run != 5'd31) begin
            st_d.run = st_q.run + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R1: no drive outside a started frame
    a_r1_quiet_outside_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !in_frame |-> !tx_en_o);

    // R9: data line low while not driving
    a_r9_data_low_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en_o |-> !tx_data_o);

    // R6: no burst longer than two slots
    a_r6_burst_limit: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run <= 5'd16);

    // R7: an inactive linear channel never drives
    a_r7_linear_inactive_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cfg.wide && !st_q.cfg.voice_on) |-> !tx_en_o);

endmodule

// File: tb/pcm_tx_formatter_tb.sv
module pcm_tx_formatter_tb;

    localparam int CLK_PERIOD = 10;
    localparam int SLOTS      = 8;
    localparam int SW         = $clog2(SLOTS);
    localparam int FB         = SLOTS * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fsync_i = 1'b0;
    logic [SW-1:0] slot_i = '0;
    logic [1:0]    mode_i = '0;
    logic          alaw_i = 1'b0;
    logic          chan_en_i = 1'b0;
    logic [15:0]   sample_i = '0;
    logic          hook_i = 1'b0;
    logic          det2_i = 1'b0;
    logic          fail_i = 1'b0;
    logic          tx_data_o;
    logic          tx_en_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pcm_tx_formatter #(.SLOTS(SLOTS)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .fsync_i   (fsync_i),
        .slot_i    (slot_i),
        .mode_i    (mode_i),
        .alaw_i    (alaw_i),
        .chan_en_i (chan_en_i),
        .sample_i  (sample_i),
        .hook_i    (hook_i),
        .det2_i    (det2_i),
        .fail_i    (fail_i),
        .tx_data_o (tx_data_o),
        .tx_en_o   (tx_en_o)
    );

    // expected {en, data} at frame position p for a captured setting
    function automatic logic [1:0] ref_bit(int p, logic [1:0] m, logic law, logic ch,
                                           logic [15:0] s, logic h, logic d2, logic f,
                                           int slot);
        int start = slot * 8;
        int rel;
        logic [7:0] cb;
        logic [7:0] sb;
        if (p < start || p >= FB) return 2'b00;
        rel = p - start;
        if (m[1]) begin
            if (ch && rel < 16) return {1'b1, s[15 - rel]};
            return 2'b00;
        end
        cb = s[7:0] ^ (law ? 8'h55 : 8'h00);
        sb = {h, d2, 3'b000, f, 2'b00};
        if (rel < 8 && ch) return {1'b1, cb[7 - rel]};
        if (m == 2'b01 && rel >= 8 && rel < 16) return {1'b1, sb[15 - rel]};
        return 2'b00;
    endfunction

    task automatic chk(string tag, int p, logic [1:0] got, logic [1:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s pos %0d: got en/data %b expected %b", tag, p, got, exp);
        end
    endtask

    task automatic run_frame(logic [1:0] m, logic law, logic ch, logic [15:0] s,
                             logic h, logic d2, logic f, int slot,
                             bit hold2, bit scramble, string tag);
        @(negedge clk);
        mode_i = m; alaw_i = law; chan_en_i = ch; sample_i = s;
        hook_i = h; det2_i = d2; fail_i = f; slot_i = SW'(slot);
        fsync_i = 1'b1;
        for (int p = 0; p < FB + 3; p++) begin
            @(negedge clk);
            chk(tag, p, {tx_en_o, tx_data_o}, ref_bit(p, m, law, ch, s, h, d2, f, slot));
            if (p == 0) begin
                fsync_i = hold2;
                if (scramble) begin
                    mode_i = 2'($urandom); alaw_i = ~law; chan_en_i = ~ch;
                    sample_i = ~s; hook_i = ~h; det2_i = ~d2; fail_i = ~f;
                    slot_i = SW'($urandom);
                end
            end
            if (p == 1) fsync_i = 1'b0;
        end
    endtask

    function automatic string tag_of(logic [1:0] m, logic law, logic ch, int slot);
        if (slot == SLOTS - 1 && (m != 2'b00)) return "R10";
        if (!ch) return "R7";
        if (m[1]) return "R5";
        if (m == 2'b01) return "R6";
        return law ? "R4" : "R3";
    endfunction

    initial begin
        void'($urandom(32'd7741));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: quiet before any frame sync
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R1", -1, {tx_en_o, tx_data_o}, 2'b00);
        end
        // directed corners
        run_frame(2'b00, 1'b0, 1'b1, 16'h00A7, 0, 0, 0, 2, 0, 0, "R3");
        run_frame(2'b00, 1'b1, 1'b1, 16'h00A7, 0, 0, 0, 3, 0, 0, "R4");
        run_frame(2'b10, 1'b1, 1'b1, 16'hB35C, 0, 0, 0, 1, 0, 0, "R5");
        run_frame(2'b11, 1'b0, 1'b1, 16'h8001, 0, 0, 0, 4, 0, 0, "R5");
        run_frame(2'b01, 1'b0, 1'b1, 16'h00F0, 1, 0, 1, 5, 0, 0, "R6");
        run_frame(2'b01, 1'b1, 1'b0, 16'h00FF, 1, 1, 1, 2, 0, 0, "R7");
        run_frame(2'b00, 1'b0, 1'b0, 16'hFFFF, 1, 1, 1, 0, 0, 0, "R7");
        run_frame(2'b10, 1'b0, 1'b0, 16'hFFFF, 1, 1, 1, 0, 0, 0, "R7");
        run_frame(2'b01, 1'b0, 1'b1, 16'h0081, 1, 1, 0, 0, 1, 0, "R2");
        run_frame(2'b10, 1'b0, 1'b1, 16'hC3A5, 0, 0, 0, 0, 1, 1, "R8");
        run_frame(2'b01, 1'b1, 1'b1, 16'h0033, 0, 1, 1, 0, 0, 1, "R8");
        run_frame(2'b10, 1'b0, 1'b1, 16'hFFFF, 0, 0, 0, SLOTS - 1, 0, 0, "R10");
        run_frame(2'b01, 1'b0, 1'b0, 16'hFFFF, 1, 1, 1, SLOTS - 1, 0, 0, "R10");
        run_frame(2'b00, 1'b0, 1'b1, 16'h0000, 0, 0, 0, 6, 0, 0, "R9");
        // random frames
        for (int k = 0; k < 150; k++) begin
            logic [1:0]  m  = 2'($urandom);
            logic        lw = 1'($urandom);
            logic        ch = ($urandom % 4) != 0;
            logic [15:0] s  = 16'($urandom);
            int          sl = $urandom % SLOTS;
            bit          h2 = ($urandom % 5) == 0;
            bit          sc = ($urandom % 3) == 0;
            string       t  = tag_of(m, lw, ch, sl);
            if (sc) t = {t, "/R8"};
            if (h2) t = {t, "/R2"};
            run_frame(m, lw, ch, s, 1'($urandom), 1'($urandom), 1'($urandom),
                      sl, h2, sc, t);
        end
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: got no completion, expected end of run");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule